// File: doc/BRIEF.md
# Shared/Dirty Status Consistency Checker

This block watches the cache-status response lines of a system bus and confirms that the status-check line always equals the logical OR of the shared and dirty lines at the moments when that relationship has to hold. It does not sample on every cycle. It samples at points that are scheduled from the send-data strobe. The first sample comes a fixed two cycles after the strobe. While the bus hold line stays asserted, another sample follows every two cycles.

When a sample shows a mismatch, the block sets a sticky data-status-error flag and pulses the bus fault line for one cycle. The mismatch can be a response line high while status-check is low, or status-check high while both response lines are low. The flag stays set until reset, so it records that at least one inconsistency occurred since the last reset. The block does not produce the bus status signals and does not use the shared or dirty information for coherence decisions.

Top module: `dstat_checker`

## Requirements
- R1: During and directly after reset, `dse_o` and `fault_o` are both 0.
- R2: A send-data strobe seen at clock edge E0 schedules exactly one sample at edge E0+2. Values on the status lines at E0+1 and E0+3 are ignored unless hold extends the sequence.
- R3: If `hold_i` is 1 at a sample edge and no new strobe arrives, a further sample is taken two edges later. This repeats for as long as hold is 1 at each sample edge.
- R4: If `hold_i` is 0 at a sample edge and no new strobe arrives, sampling stops after that sample. Later mismatches have no effect on `dse_o` or `fault_o` until the next strobe.
- R5: A sample where `shared_i` or `dirty_i` is 1 while `statchk_i` is 0 is an error.
- R6: A sample where `statchk_i` is 1 while both `shared_i` and `dirty_i` are 0 is an error.
- R7: A sample where `statchk_i` equals `shared_i | dirty_i` raises no error. This covers all four consistent combinations.
- R8: An error at sample edge E makes `fault_o` 1 for exactly the cycle after E. It also sets `dse_o`, which then stays 1 until reset.
- R9: A strobe that arrives while a sequence is active restarts the schedule, so that the next sample is two edges after the new strobe.
- R10: Without a strobe, no sample is taken, so mismatches on the status lines have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| send_data_i | input | 1 | Send-data strobe, 1 for one cycle per data transfer |
| hold_i | input | 1 | Bus hold; extends sampling at each sample point |
| shared_i | input | 1 | Shared response line |
| dirty_i | input | 1 | Dirty response line |
| statchk_i | input | 1 | Status-check line, expected to equal shared OR dirty |
| dse_o | output | 1 | Sticky data-status-error flag |
| fault_o | output | 1 | Bus fault, one-cycle pulse per detected error |

## Verification
The assertions assume that all inputs are synchronous to `clk_i` and stable around its rising edge. Their timing checks also assume the default offset and repeat period of two. The first-sample assertion is only evaluated once three edges have passed since reset, so it never uses strobe values from the reset period. The bench keeps within these assumptions: it changes every input on the falling edge, holds the strobe low throughout reset, and applies status values only at the edges it intends as sample points or as deliberately ignored off-schedule cycles.

// File: rtl/dstat_pkg.sv
package dstat_pkg;

    // Registered result flags of the checker
    typedef struct packed {
        logic dse;    // sticky data-status-error
        logic fault;  // one-cycle fault pulse
    } dstat_flags_t;

    // True when the status-check line disagrees with shared OR dirty
    function automatic logic status_mismatch(input logic shared_v,
                                             input logic dirty_v,
                                             input logic statchk_v);
        return statchk_v != (shared_v | dirty_v);
    endfunction

endpackage

// File: rtl/dstat_sched.sv
module dstat_sched #(
    parameter int unsigned OFFSET = 2,  // edges from strobe to first sample
    parameter int unsigned PERIOD = 2   // edges between samples while held
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic strobe_i,
    input  logic hold_i,
    output logic sample_o
);
    localparam int unsigned MAXV  = (OFFSET > PERIOD) ? OFFSET : PERIOD;
    localparam int unsigned CNT_W = (MAXV > 1) ? $clog2(MAXV) : 1;
    localparam logic [CNT_W-1:0] OFF_LOAD = CNT_W'(OFFSET - 1);
    localparam logic [CNT_W-1:0] PER_LOAD = CNT_W'(PERIOD - 1);

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
    } sched_t;

    sched_t s_d, s_q;
    logic   at_point;

    assign at_point = s_q.active && (s_q.cnt == '0);
    assign sample_o = at_point;

    always_comb begin
        s_d = s_q;
        if (strobe_i) begin
            // new strobe always restarts the schedule
            s_d.active = 1'b1;
            s_d.cnt    = OFF_LOAD;
        end else if (at_point) begin
            if (hold_i) begin
                s_d.cnt = PER_LOAD;
            end else begin
                s_d.active = 1'b0;
            end
        end else if (s_q.active) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/dstat_cmp.sv
module dstat_cmp (
    input  logic sample_i,
    input  logic shared_i,
    input  logic dirty_i,
    input  logic statchk_i,
    output logic err_o
);
    import dstat_pkg::*;

    always_comb begin
        err_o = sample_i && status_mismatch(shared_i, dirty_i, statchk_i);
    end

endmodule

// File: rtl/dstat_checker.sv
module dstat_checker #(
    parameter int unsigned OFFSET = 2,
    parameter int unsigned PERIOD = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic send_data_i,
    input  logic hold_i,
    input  logic shared_i,
    input  logic dirty_i,
    input  logic statchk_i,
    output logic dse_o,
    output logic fault_o
);
    import dstat_pkg::*;

    logic         sample_pt;
    logic         err;
    dstat_flags_t f_d, f_q;

    dstat_sched #(
        .OFFSET (OFFSET),
        .PERIOD (PERIOD)
    ) u_sched (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .strobe_i (send_data_i),
        .hold_i   (hold_i),
        .sample_o (sample_pt)
    );

    dstat_cmp u_cmp (
        .sample_i  (sample_pt),
        .shared_i  (shared_i),
        .dirty_i   (dirty_i),
        .statchk_i (statchk_i),
        .err_o     (err)
    );

    always_comb begin
        f_d       = f_q;
        f_d.fault = err;
        f_d.dse   = f_q.dse | err;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign dse_o   = f_q.dse;
    assign fault_o = f_q.fault;

endmodule

// File: rtl/dstat_checker_sva.sv
module dstat_checker_sva #(
    parameter int unsigned OFFSET = 2,
    parameter int unsigned PERIOD = 2
) (
    input logic clk_i,
    input logic rst_ni,
    input logic send_data_i,
    input logic hold_i,
    input logic shared_i,
    input logic dirty_i,
    input logic statchk_i,
    input logic dse_o,
    input logic fault_o,
    input logic sample_pt
);
    logic [1:0] age_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            age_q <= '0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 2'd1;
        end
    end

    // R1: flags clear right after reset
    a_r1_reset_clear: assert property (@(posedge clk_i)
        $rose(rst_ni) |-> !dse_o && !fault_o);

    // R5 and R6: any inconsistent sample flags an error
    a_r5_mismatch_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sample_pt && (statchk_i != (shared_i | dirty_i)) |=> fault_o && dse_o);

    a_r7_clean_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sample_pt && (statchk_i == (shared_i | dirty_i)) |=> !fault_o);

    a_r8_fault_from_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_o |-> $past(sample_pt));

    a_r8_dse_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dse_o |=> dse_o);

    a_r4_stop_on_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sample_pt && !hold_i && !send_data_i |=> !sample_pt);

    a_r10_sample_needs_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sample_pt |-> (age_q != 2'd0));

    generate
        if (OFFSET == 2) begin : g_off2
            // R2 and R9: sample exactly two edges after the latest strobe
            a_r2_first_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (age_q == 2'd3) && $past(send_data_i, 2) && !$past(send_data_i, 1)
                |-> sample_pt);
        end
        if (PERIOD == 2) begin : g_per2
            a_r3_hold_repeat: assert property (@(posedge clk_i) disable iff (!rst_ni)
                sample_pt && hold_i && !send_data_i |=> !sample_pt ##1 sample_pt);
        end
    endgenerate

endmodule

bind dstat_checker dstat_checker_sva #(
    .OFFSET (OFFSET),
    .PERIOD (PERIOD)
) u_sva (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .send_data_i (send_data_i),
    .hold_i      (hold_i),
    .shared_i    (shared_i),
    .dirty_i     (dirty_i),
    .statchk_i   (statchk_i),
    .dse_o       (dse_o),
    .fault_o     (fault_o),
    .sample_pt   (sample_pt)
);

// File: tb/tb_dstat_checker.sv
module tb_dstat_checker;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic send_data = 1'b0;
    logic hold = 1'b0;
    logic shared = 1'b0;
    logic dirty = 1'b0;
    logic statchk = 1'b0;
    logic dse;
    logic fault;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dstat_checker dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .send_data_i (send_data),
        .hold_i      (hold),
        .shared_i    (shared),
        .dirty_i     (dirty),
        .statchk_i   (statchk),
        .dse_o       (dse),
        .fault_o     (fault)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    // Drive inputs for the next rising edge, then move past it.
    task automatic cyc(input logic s, input logic h, input logic st,
                       input logic sh, input logic di);
        send_data = s; hold = h; statchk = st; shared = sh; dirty = di;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cyc(0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 dse after reset", dse, 1'b0);
        check("R1 fault after reset", fault, 1'b0);
    endtask

    task automatic t_first_sample();
        do_reset();
        cyc(1, 0, 0, 0, 0);           // E0 strobe
        cyc(0, 0, 0, 1, 0);           // E1 mismatch, off schedule
        check("R2 E1 ignored", fault, 1'b0);
        cyc(0, 0, 0, 1, 0);           // E2 shared without statchk
        check("R5 fault after shared/no statchk", fault, 1'b1);
        check("R8 dse set", dse, 1'b1);
        cyc(0, 0, 0, 1, 0);           // E3 mismatch, off schedule
        check("R8 fault one cycle", fault, 1'b0);
        check("R2 E3 ignored / R8 dse sticky", dse, 1'b1);
        cyc(0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);
        check("R8 dse still sticky", dse, 1'b1);
    endtask

    task automatic t_dirty_err();
        do_reset();
        cyc(1, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 1);
        check("R5 fault after dirty/no statchk", fault, 1'b1);
    endtask

    task automatic t_statchk_err();
        do_reset();
        cyc(1, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);
        cyc(0, 0, 1, 0, 0);
        check("R6 fault after lone statchk", fault, 1'b1);
        check("R6 dse after lone statchk", dse, 1'b1);
    endtask

    task automatic t_clean();
        logic seen;
        do_reset();
        seen = 1'b0;
        for (int k = 0; k < 4; k++) begin
            logic sh, di;
            sh = k[0]; di = k[1];
            cyc(1, 0, 0, 0, 0);
            cyc(0, 0, 0, 0, 0);
            cyc(0, 0, sh | di, sh, di);
            seen = seen | fault;
            cyc(0, 0, 0, 0, 0);
        end
        check("R7 no fault on consistent samples", seen, 1'b0);
        check("R7 no dse on consistent samples", dse, 1'b0);
    endtask

    task automatic t_hold();
        do_reset();
        cyc(1, 0, 0, 0, 0);           // E0
        cyc(0, 0, 0, 0, 0);           // E1
        cyc(0, 1, 1, 1, 1);           // E2 clean, held
        cyc(0, 1, 1, 0, 0);           // E3 mismatch off schedule
        check("R3 off-schedule ignored while held", fault, 1'b0);
        cyc(0, 1, 0, 0, 0);           // E4 clean, held
        check("R3 clean held sample", fault, 1'b0);
        cyc(0, 1, 0, 1, 0);           // E5 off schedule
        check("R3 E5 ignored", dse, 1'b0);
        cyc(0, 0, 0, 0, 1);           // E6 repeated sample, mismatch
        check("R3 repeated sample catches error", fault, 1'b1);
    endtask

    task automatic t_release();
        do_reset();
        cyc(1, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);           // E2 clean, hold low
        for (int k = 0; k < 6; k++) cyc(0, 1, 1, 0, 0);
        check("R4 no sampling after release", dse, 1'b0);
    endtask

    task automatic t_restart();
        do_reset();
        cyc(1, 0, 0, 0, 0);           // E0
        cyc(1, 0, 0, 0, 0);           // E1 new strobe restarts
        cyc(0, 0, 1, 0, 0);           // E2 old slot, now ignored
        check("R9 old slot skipped", fault, 1'b0);
        cyc(0, 0, 1, 0, 0);           // E3 new slot
        check("R9 restarted slot sampled", fault, 1'b1);
    endtask

    task automatic t_no_strobe();
        do_reset();
        for (int k = 0; k < 10; k++) cyc(0, k[0], 1, 0, 0);
        check("R10 no sample without strobe", dse, 1'b0);
    endtask

    initial begin
        @(negedge clk);
        check("R1 dse during reset", dse, 1'b0);
        t_reset();
        t_first_sample();
        t_dirty_err();
        t_statchk_err();
        t_clean();
        t_hold();
        t_release();
        t_restart();
        t_no_strobe();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule